// File: doc/BRIEF.md
# Configurable GPIO port controller

The block is an eight-pin general-purpose I/O port behind a simple word-addressed register bus. Every pin can be a software-controlled digital input or output, or it can be handed over to an alternate peripheral. When a pin is handed over, the peripheral sets both the pin's direction and its value. Per-pin control bits select open-drain signalling, pull-up or pull-down resolution of an undriven line, and digital enable. A register of designated protected pins guards their pad configuration behind a lock key.

Each pin's input passes through a two-flop synchroniser and feeds an interrupt unit. Per pin, that unit can detect a rising edge, a falling edge, both edges, a high level or a low level. It keeps a raw status that software clears by writing ones, and a masked status that drives a single port interrupt line. The same pin events can be routed, per pin, to a one-cycle ADC trigger pulse and a one-cycle DMA request pulse. Analog select, drive strength and slew control are stored and read back only.

The pad itself is modelled at the boundary. `pad_ext` and `pad_ext_drv` describe what the outside world does to each line, and `pad_out` and `pad_oe` describe what the port drives.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset no pin is driven (`pad_oe` all 0). Alternate select (word address 2), digital enable (address 6) and pull-up (address 4) read back as the protected-pin set `PROT` (default 0xC0). Every other configuration register reads 0, and the lock register (address 18) reads 1.
- R2: With alternate select 0 and digital enable 1, a 1 in the direction register (address 1) drives the pin push-pull with the value written to the data register (address 0). A 0 in the direction register leaves the pin undriven as an input.
- R3: With the open-drain bit (address 3) set on a software-controlled output, a data bit of 0 drives the pin low, and a data bit of 1 releases it (`pad_oe` 0).
- R4: With alternate select set, the pin's direction comes from `alt_oe` and its value from `alt_out`, and the direction register has no effect. The open-drain bit still turns a 1 into a released pin.
- R5: A pin whose digital-enable bit is 0 is never driven, reads 0 in the data register, and produces no interrupt status.
- R6: The level seen on a line that nothing drives is 1 if its pull-up bit (address 4) is set. Otherwise it is 0 if its pull-down bit (address 5) is set, and otherwise it is the `pad_ext` value. Pull-up wins when both are set.
- R7: A read of the data register (address 0) shows a changed pin level two clock edges after the change, and not after one.
- R8: In edge mode (bit 0 at address 10), event bit 1 at address 12 selects rising and 0 selects falling. A 1 at address 11 makes either edge count. The raw status bit (address 14) sets on the third clock edge after the pin change. It then holds until a 1 is written to that bit at address 14.
- R9: In level mode (bit 1 at address 10), the raw status bit follows the match of the pin to the selected level (event 1 = high, 0 = low). A write of 1 to address 14 does not clear it while the level persists.
- R10: Raw status latches whatever the mask (address 13) holds. The masked status (address 15) equals raw AND mask, and `irq` is high exactly when any masked bit is set.
- R11: While locked, writes to addresses 2 to 6 leave the bits of the protected pins unchanged and update the rest. Writing 0x4C4F434B to address 18 unlocks it, and the register then reads 0. Any other value written there locks it again, and it reads 1.
- R12: `adc_trig` (enable register address 16) and `dma_trig` (address 17) go high for the clock cycle after a pin event on an enabled pin, and stay low for pins that are not enabled.
- R13: Analog select (address 7), drive strength (address 8) and slew (address 9) read back what was written and have no effect on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pad_ext | input | 8 | Line level presented from outside |
| pad_ext_drv | input | 8 | Outside driver active per line |
| pad_out | output | 8 | Value the port drives |
| pad_oe | output | 8 | Port output enable per line |
| alt_out | input | 8 | Alternate peripheral output value |
| alt_oe | input | 8 | Alternate peripheral direction (1 = drive) |
| alt_in | output | 8 | Synchronised, enable-gated pin levels for the peripheral |
| irq | output | 1 | Port interrupt |
| adc_trig | output | 1 | ADC trigger pulse |
| dma_trig | output | 1 | DMA request pulse |

## Verification
The hardest cases to reach from the ports are the ones where configuration and pin activity overlap. Examples are an edge that lands while the pin is masked, a clear written while a level condition still holds, and protected bits that must survive writes while locked. The stimulus reaches them by scripted ordering: it changes a pin level first, then changes the mask, sense or lock state, and only after that writes a clear. A cycle-by-cycle behavioural model in the bench follows the synchroniser delay. That model checks the pad drive, interrupt and trigger pulses on every clock.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int REG_AW = 5;
  localparam int BUS_W  = 32;

  localparam logic [REG_AW-1:0] RA_DATA  = 5'd0;
  localparam logic [REG_AW-1:0] RA_DIR   = 5'd1;
  localparam logic [REG_AW-1:0] RA_ALT   = 5'd2;
  localparam logic [REG_AW-1:0] RA_ODR   = 5'd3;
  localparam logic [REG_AW-1:0] RA_PUP   = 5'd4;
  localparam logic [REG_AW-1:0] RA_PDN   = 5'd5;
  localparam logic [REG_AW-1:0] RA_DEN   = 5'd6;
  localparam logic [REG_AW-1:0] RA_ANA   = 5'd7;
  localparam logic [REG_AW-1:0] RA_DRV   = 5'd8;
  localparam logic [REG_AW-1:0] RA_SLEW  = 5'd9;
  localparam logic [REG_AW-1:0] RA_SENSE = 5'd10;
  localparam logic [REG_AW-1:0] RA_BOTH  = 5'd11;
  localparam logic [REG_AW-1:0] RA_EVT   = 5'd12;
  localparam logic [REG_AW-1:0] RA_MASK  = 5'd13;
  localparam logic [REG_AW-1:0] RA_RAW   = 5'd14;
  localparam logic [REG_AW-1:0] RA_MIS   = 5'd15;
  localparam logic [REG_AW-1:0] RA_ADCEN = 5'd16;
  localparam logic [REG_AW-1:0] RA_DMAEN = 5'd17;
  localparam logic [REG_AW-1:0] RA_LOCK  = 5'd18;

  localparam logic [BUS_W-1:0] UNLOCK_KEY = 32'h4C4F434B;

  // Level seen on one line: own driver, then outside driver, then pulls.
  function automatic logic pad_level(input logic oe, input logic out,
                                     input logic ext_drv, input logic ext_val,
                                     input logic pup, input logic pdn);
    if (oe)           return out;
    else if (ext_drv) return ext_val;
    else if (pup)     return 1'b1;
    else if (pdn)     return 1'b0;
    else              return ext_val;
  endfunction

  function automatic logic edge_hit(input logic cur, input logic prev,
                                    input logic both, input logic rising);
    if (both)        return cur ^ prev;
    else if (rising) return cur & ~prev;
    else             return ~cur & prev;
  endfunction

  function automatic logic level_hit(input logic cur, input logic high);
    return ~(cur ^ high);
  endfunction

endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_port_pkg::*;
#(
  parameter int N = 8,
  parameter logic [N-1:0] PROT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [N-1:0]      din,
  input  logic [N-1:0]      raw,
  input  logic [N-1:0]      mis,
  output logic [BUS_W-1:0]  rdata,
  output logic [N-1:0]      data_o,
  output logic [N-1:0]      dir_o,
  output logic [N-1:0]      alt_o,
  output logic [N-1:0]      odr_o,
  output logic [N-1:0]      pup_o,
  output logic [N-1:0]      pdn_o,
  output logic [N-1:0]      den_o,
  output logic [N-1:0]      sense_o,
  output logic [N-1:0]      both_o,
  output logic [N-1:0]      evt_o,
  output logic [N-1:0]      mask_o,
  output logic [N-1:0]      adc_o,
  output logic [N-1:0]      dma_o,
  output logic [N-1:0]      clr_o,
  output logic              locked_o
);

  localparam int FILL = BUS_W - N;

  logic [N-1:0] ana_q, drv_q, slew_q;
  logic [N-1:0] wv;

  assign wv = wdata[N-1:0];

  // Protected pins keep their bits while the lock is closed.
  function automatic logic [N-1:0] guard(input logic [N-1:0] cur, input logic [N-1:0] nxt);
    return locked_o ? ((cur & PROT) | (nxt & ~PROT)) : nxt;
  endfunction

  function automatic logic [BUS_W-1:0] widen(input logic [N-1:0] v);
    return {{FILL{1'b0}}, v};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o <= '0;  dir_o <= '0;   alt_o <= PROT; odr_o <= '0;
      pup_o <= PROT; pdn_o <= '0;   den_o <= PROT;
      ana_q <= '0;   drv_q <= '0;   slew_q <= '0;
      sense_o <= '0; both_o <= '0;  evt_o <= '0;  mask_o <= '0;
      adc_o <= '0;   dma_o <= '0;   locked_o <= 1'b1;
    end else if (we) begin
      case (addr)
        RA_DATA:  data_o  <= wv;
        RA_DIR:   dir_o   <= wv;
        RA_ALT:   alt_o   <= guard(alt_o, wv);
        RA_ODR:   odr_o   <= guard(odr_o, wv);
        RA_PUP:   pup_o   <= guard(pup_o, wv);
        RA_PDN:   pdn_o   <= guard(pdn_o, wv);
        RA_DEN:   den_o   <= guard(den_o, wv);
        RA_ANA:   ana_q   <= wv;
        RA_DRV:   drv_q   <= wv;
        RA_SLEW:  slew_q  <= wv;
        RA_SENSE: sense_o <= wv;
        RA_BOTH:  both_o  <= wv;
        RA_EVT:   evt_o   <= wv;
        RA_MASK:  mask_o  <= wv;
        RA_ADCEN: adc_o   <= wv;
        RA_DMAEN: dma_o   <= wv;
        RA_LOCK:  locked_o <= (wdata != UNLOCK_KEY);
        default: ;
      endcase
    end
  end

  always_comb begin
    clr_o = (we && addr == RA_RAW) ? wv : '0;
  end

  always_comb begin
    case (addr)
      RA_DATA:  rdata = widen(din);
      RA_DIR:   rdata = widen(dir_o);
      RA_ALT:   rdata = widen(alt_o);
      RA_ODR:   rdata = widen(odr_o);
      RA_PUP:   rdata = widen(pup_o);
      RA_PDN:   rdata = widen(pdn_o);
      RA_DEN:   rdata = widen(den_o);
      RA_ANA:   rdata = widen(ana_q);
      RA_DRV:   rdata = widen(drv_q);
      RA_SLEW:  rdata = widen(slew_q);
      RA_SENSE: rdata = widen(sense_o);
      RA_BOTH:  rdata = widen(both_o);
      RA_EVT:   rdata = widen(evt_o);
      RA_MASK:  rdata = widen(mask_o);
      RA_RAW:   rdata = widen(raw);
      RA_MIS:   rdata = widen(mis);
      RA_ADCEN: rdata = widen(adc_o);
      RA_DMAEN: rdata = widen(dma_o);
      RA_LOCK:  rdata = {{(BUS_W-1){1'b0}}, locked_o};
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
  import gpio_port_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] alt_sel,
  input  logic [N-1:0] dir,
  input  logic [N-1:0] odr,
  input  logic [N-1:0] den,
  input  logic [N-1:0] data,
  input  logic [N-1:0] alt_out,
  input  logic [N-1:0] alt_oe,
  input  logic [N-1:0] pup,
  input  logic [N-1:0] pdn,
  input  logic [N-1:0] ext_val,
  input  logic [N-1:0] ext_drv,
  output logic [N-1:0] pad_oe,
  output logic [N-1:0] pad_out,
  output logic [N-1:0] lvl
);

  for (genvar g = 0; g < N; g++) begin : g_pin
    logic want_drive;
    logic value;

    assign want_drive = alt_sel[g] ? alt_oe[g]  : dir[g];
    assign value      = alt_sel[g] ? alt_out[g] : data[g];
    // Open drain: a 1 becomes a release, only a 0 is driven.
    assign pad_oe[g]  = den[g] & (odr[g] ? (want_drive & ~value) : want_drive);
    assign pad_out[g] = odr[g] ? 1'b0 : value;
    assign lvl[g]     = pad_level(pad_oe[g], pad_out[g], ext_drv[g], ext_val[g], pup[g], pdn[g]);
  end

endmodule

// File: rtl/gpio_evt_unit.sv
module gpio_evt_unit
  import gpio_port_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] den,
  input  logic [N-1:0] sense,
  input  logic [N-1:0] both,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] adc_en,
  input  logic [N-1:0] dma_en,
  output logic [N-1:0] din,
  output logic [N-1:0] raw,
  output logic [N-1:0] pin_evt,
  output logic         adc_trig,
  output logic         dma_trig
);

  logic [N-1:0] sync1_q, sync2_q, prev_q;

  assign din = sync2_q & den;

  for (genvar g = 0; g < N; g++) begin : g_det
    assign pin_evt[g] = den[g] & (sense[g] ? level_hit(din[g], evt[g])
                                           : edge_hit(din[g], prev_q[g], both[g], evt[g]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q  <= '0;
      sync2_q  <= '0;
      prev_q   <= '0;
      raw      <= '0;
      adc_trig <= 1'b0;
      dma_trig <= 1'b0;
    end else begin
      sync1_q  <= lvl;
      sync2_q  <= sync1_q;
      prev_q   <= din;
      // Level bits follow the condition; edge bits hold until cleared.
      raw      <= (sense & pin_evt) | (~sense & (pin_evt | (raw & ~clr)));
      adc_trig <= |(pin_evt & adc_en);
      dma_trig <= |(pin_evt & dma_en);
    end
  end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int N = 8,
  parameter logic [N-1:0] PROT = 8'hC0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [N-1:0]      pad_ext,
  input  logic [N-1:0]      pad_ext_drv,
  output logic [N-1:0]      pad_out,
  output logic [N-1:0]      pad_oe,
  input  logic [N-1:0]      alt_out,
  input  logic [N-1:0]      alt_oe,
  output logic [N-1:0]      alt_in,
  output logic              irq,
  output logic              adc_trig,
  output logic              dma_trig
);

  logic [N-1:0] cfg_data, cfg_dir, cfg_alt, cfg_odr, cfg_pup, cfg_pdn, cfg_den;
  logic [N-1:0] cfg_sense, cfg_both, cfg_evt, cfg_mask, cfg_adc, cfg_dma;
  logic [N-1:0] clr_bits, din, raw_st, mis_st, pin_evt, pin_lvl;
  logic         cfg_locked;

  assign mis_st = raw_st & cfg_mask;
  assign irq    = |mis_st;
  assign alt_in = din;

  gpio_cfg_regs #(.N(N), .PROT(PROT)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .din(din), .raw(raw_st), .mis(mis_st), .rdata(bus_rdata),
    .data_o(cfg_data), .dir_o(cfg_dir), .alt_o(cfg_alt), .odr_o(cfg_odr),
    .pup_o(cfg_pup), .pdn_o(cfg_pdn), .den_o(cfg_den), .sense_o(cfg_sense),
    .both_o(cfg_both), .evt_o(cfg_evt), .mask_o(cfg_mask), .adc_o(cfg_adc),
    .dma_o(cfg_dma), .clr_o(clr_bits), .locked_o(cfg_locked)
  );

  gpio_pad_mux #(.N(N)) u_pads (
    .alt_sel(cfg_alt), .dir(cfg_dir), .odr(cfg_odr), .den(cfg_den), .data(cfg_data),
    .alt_out(alt_out), .alt_oe(alt_oe), .pup(cfg_pup), .pdn(cfg_pdn),
    .ext_val(pad_ext), .ext_drv(pad_ext_drv),
    .pad_oe(pad_oe), .pad_out(pad_out), .lvl(pin_lvl)
  );

  gpio_evt_unit #(.N(N)) u_evt (
    .clk(clk), .rst_n(rst_n), .lvl(pin_lvl), .den(cfg_den), .sense(cfg_sense),
    .both(cfg_both), .evt(cfg_evt), .clr(clr_bits), .adc_en(cfg_adc), .dma_en(cfg_dma),
    .din(din), .raw(raw_st), .pin_evt(pin_evt), .adc_trig(adc_trig), .dma_trig(dma_trig)
  );

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
  parameter int N = 8,
  parameter logic [N-1:0] PROT = '0
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] pad_oe,
  input logic [N-1:0] den,
  input logic [N-1:0] alt,
  input logic [N-1:0] sense,
  input logic [N-1:0] mask,
  input logic [N-1:0] raw,
  input logic [N-1:0] clr,
  input logic         locked,
  input logic         irq,
  input logic         adc_trig,
  input logic [N-1:0] adc_en
);

  // R5: a pin with digital enable off is never driven
  a_r5_off_pin_undriven: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~den) == '0);

  // R8: an edge-mode status bit stays set unless cleared
  a_r8_edge_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw & ~sense & ~clr) != '0) |=> (($past(raw & ~sense & ~clr) & ~sense & ~raw) == '0));

  // R10: the port interrupt needs an unmasked raw bit
  a_r10_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((raw & mask) != '0));

  // R11: protected bits do not move while locked
  a_r11_protected_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(locked) |-> ((((alt ^ $past(alt)) | (den ^ $past(den))) & PROT) == '0));

  // R12: a trigger pulse needs an enabled source in the cycle before
  a_r12_trig_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig |-> ($past(adc_en) != '0));

endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.N(N), .PROT(PROT)) u_chk (
  .clk(clk), .rst_n(rst_n), .pad_oe(pad_oe), .den(cfg_den), .alt(cfg_alt),
  .sense(cfg_sense), .mask(cfg_mask), .raw(raw_st), .clr(clr_bits),
  .locked(cfg_locked), .irq(irq), .adc_trig(adc_trig), .adc_en(cfg_adc)
);

// File: tb/gpio_port_ctrl_test.sv
`timescale 1ns/1ps
module gpio_port_ctrl_test;

  localparam int N = 8;
  localparam logic [7:0] PROT = 8'hC0;
  localparam logic [31:0] KEY = 32'h4C4F434B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pad_ext = '0, pad_ext_drv = '0, alt_out = '0, alt_oe = '0;
  logic [7:0]  pad_out, pad_oe, alt_in;
  logic        irq, adc_trig, dma_trig;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_port_ctrl #(.N(N), .PROT(PROT)) uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_ext(pad_ext),
    .pad_ext_drv(pad_ext_drv), .pad_out(pad_out), .pad_oe(pad_oe),
    .alt_out(alt_out), .alt_oe(alt_oe), .alt_in(alt_in), .irq(irq),
    .adc_trig(adc_trig), .dma_trig(dma_trig)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] mr [0:18];
  bit          mlock;
  logic [7:0]  s1, s2, prv, mraw;
  logic        madc, mdma;

  function automatic void mpad(output logic [7:0] oe, output logic [7:0] out, output logic [7:0] lvl);
    for (int i = 0; i < 8; i++) begin
      logic dr, v;
      if (mr[2][i]) begin dr = alt_oe[i]; v = alt_out[i]; end
      else          begin dr = mr[1][i];  v = mr[0][i];   end
      if (!mr[6][i])     begin oe[i] = 1'b0;      out[i] = 1'b0; end
      else if (mr[3][i]) begin oe[i] = dr && !v;  out[i] = 1'b0; end
      else               begin oe[i] = dr;        out[i] = v;    end
      if (oe[i])               lvl[i] = out[i];
      else if (pad_ext_drv[i]) lvl[i] = pad_ext[i];
      else if (mr[4][i])       lvl[i] = 1'b1;
      else if (mr[5][i])       lvl[i] = 1'b0;
      else                     lvl[i] = pad_ext[i];
    end
  endfunction

  always @(posedge clk) begin : model_step
    logic [7:0] oe, out, lvl, sp, hit, clr;
    if (!rst_n) begin
      for (int a = 0; a < 19; a++) mr[a] = '0;
      mr[2] = {24'b0, PROT}; mr[4] = {24'b0, PROT}; mr[6] = {24'b0, PROT};
      mlock = 1'b1; s1 = '0; s2 = '0; prv = '0; mraw = '0; madc = 1'b0; mdma = 1'b0;
    end else begin
      mpad(oe, out, lvl);
      sp  = s2 & mr[6][7:0];
      clr = (bus_we && bus_addr == 5'd14) ? bus_wdata[7:0] : 8'h00;
      for (int i = 0; i < 8; i++) begin
        if (!mr[6][i])          hit[i] = 1'b0;
        else if (mr[10][i])     hit[i] = (sp[i] == mr[12][i]);
        else if (mr[11][i])     hit[i] = (sp[i] != prv[i]);
        else if (mr[12][i])     hit[i] = sp[i] && !prv[i];
        else                    hit[i] = !sp[i] && prv[i];
        if (mr[10][i]) mraw[i] = hit[i];
        else           mraw[i] = hit[i] || (mraw[i] && !clr[i]);
      end
      madc = |(hit & mr[16][7:0]);
      mdma = |(hit & mr[17][7:0]);
      prv = sp; s2 = s1; s1 = lvl;
      if (bus_we) begin
        if (bus_addr == 5'd18) mlock = (bus_wdata != KEY);
        else if (bus_addr >= 5'd2 && bus_addr <= 5'd6)
          mr[bus_addr] = {24'b0, mlock ? ((mr[bus_addr][7:0] & PROT) | (bus_wdata[7:0] & ~PROT))
                                       : bus_wdata[7:0]};
        else if (bus_addr <= 5'd17 && bus_addr != 5'd14 && bus_addr != 5'd15)
          mr[bus_addr] = {24'b0, bus_wdata[7:0]};
      end
    end
  end

  // Compared on every clock, away from the active edge.
  always @(negedge clk) begin : model_cmp
    logic [7:0] eo, eu, el;
    if (rst_n && !done) begin
      mpad(eo, eu, el);
      chk("R2", "pad_oe vs model", {24'b0, pad_oe}, {24'b0, eo});
      chk("R3", "driven pad_out vs model", {24'b0, pad_out & pad_oe}, {24'b0, eu & eo});
      chk("R10", "irq vs model", {31'b0, irq}, {31'b0, |(mraw & mr[13][7:0])});
      chk("R12", "adc_trig vs model", {31'b0, adc_trig}, {31'b0, madc});
      chk("R12", "dma_trig vs model", {31'b0, dma_trig}, {31'b0, mdma});
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick(1);
    bus_we = 1'b0;
  endtask

  task automatic rdm(input logic [4:0] a, input logic [31:0] msk, input logic [31:0] e, input string tag);
    bus_addr = a;
    #1;
    chk(tag, $sformatf("read addr %0d", a), bus_rdata & msk, e);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    int cnt_a, cnt_d;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    chk("R1", "pad_oe after reset", {24'b0, pad_oe}, 32'h0);
    rdm(5'd2, '1, 32'hC0, "R1");
    rdm(5'd6, '1, 32'hC0, "R1");
    rdm(5'd4, '1, 32'hC0, "R1");
    rdm(5'd1, '1, 32'h0, "R1");
    rdm(5'd18, '1, 32'h1, "R1");

    // R11 lock
    wr(5'd2, 32'h0);   rdm(5'd2, '1, 32'hC0, "R11");
    wr(5'd6, 32'h3F);  rdm(5'd6, '1, 32'hFF, "R11");
    wr(5'd18, KEY);    rdm(5'd18, '1, 32'h0, "R11");
    wr(5'd2, 32'h0);   rdm(5'd2, '1, 32'h0, "R11");
    wr(5'd18, 32'h0);  rdm(5'd18, '1, 32'h1, "R11");
    wr(5'd2, 32'hFF);  rdm(5'd2, '1, 32'h3F, "R11");
    wr(5'd2, 32'h0);   rdm(5'd2, '1, 32'h0, "R11");

    // R2 push-pull outputs on pins 0..3
    wr(5'd1, 32'h0F);
    wr(5'd0, 32'h05);
    chk("R2", "pad_oe push-pull", {24'b0, pad_oe}, 32'h0F);
    chk("R2", "pad_out push-pull", {28'b0, pad_out[3:0]}, 32'h5);
    tick(2);
    rdm(5'd0, '1, 32'hC5, "R2");

    // R3 open drain on pin 1
    wr(5'd3, 32'h02);
    chk("R3", "od low drives", {24'b0, pad_oe}, 32'h0F);
    chk("R3", "od drives 0", {31'b0, pad_out[1]}, 32'h0);
    wr(5'd0, 32'h07);
    chk("R3", "od high releases", {24'b0, pad_oe}, 32'h0D);

    // R4 alternate function on pin 4
    alt_oe = 8'h10; alt_out = 8'h10;
    wr(5'd2, 32'h10);
    chk("R4", "alt drives", {24'b0, pad_oe}, 32'h1D);
    chk("R4", "alt value", {31'b0, pad_out[4]}, 32'h1);
    alt_oe = 8'h00;
    wr(5'd1, 32'h1F);
    chk("R4", "dir ignored under alt", {24'b0, pad_oe}, 32'h0D);
    alt_oe = 8'h10;
    wr(5'd3, 32'h12);
    chk("R4", "alt od release", {24'b0, pad_oe}, 32'h0D);
    alt_out = 8'h00; #1;
    chk("R4", "alt od low", {24'b0, pad_oe}, 32'h1D);

    // R5 digital enable off
    wr(5'd6, 32'h00);
    chk("R5", "disabled pins undriven", {24'b0, pad_oe}, 32'h0);
    pad_ext_drv = 8'h20; pad_ext = 8'h20;
    tick(3);
    rdm(5'd0, 32'h3F, 32'h0, "R5");
    wr(5'd6, 32'hFF);
    wr(5'd2, 32'h0); wr(5'd3, 32'h0); wr(5'd1, 32'h0); wr(5'd0, 32'h0);
    alt_oe = 8'h00; pad_ext_drv = 8'h00;

    // R6 pull resolution on pin 5 (floating line presented as 1)
    wr(5'd4, 32'h20); tick(2); rdm(5'd0, 32'h20, 32'h20, "R6");
    pad_ext = 8'h00;
    tick(2); rdm(5'd0, 32'h20, 32'h20, "R6");
    wr(5'd4, 32'h00); wr(5'd5, 32'h20); tick(2); rdm(5'd0, 32'h20, 32'h00, "R6");
    wr(5'd4, 32'h20); tick(2); rdm(5'd0, 32'h20, 32'h20, "R6");
    wr(5'd4, 32'h00); wr(5'd5, 32'h00); pad_ext = 8'h20;
    tick(2); rdm(5'd0, 32'h20, 32'h20, "R6");
    pad_ext = 8'h00; pad_ext_drv = 8'h08;
    tick(4);

    // R7 two-edge input latency on pin 3
    pad_ext[3] = 1'b1;
    tick(1); rdm(5'd0, 32'h08, 32'h00, "R7");
    tick(1); rdm(5'd0, 32'h08, 32'h08, "R7");
    pad_ext[3] = 1'b0;
    tick(4);

    // R8 rising edge, sticky, clear
    wr(5'd12, 32'h08);
    wr(5'd14, 32'hFF);
    pad_ext[3] = 1'b1;
    tick(2); rdm(5'd14, 32'h08, 32'h00, "R8");
    tick(1); rdm(5'd14, 32'h08, 32'h08, "R8");
    pad_ext[3] = 1'b0;
    tick(4); rdm(5'd14, 32'h08, 32'h08, "R8");

    // R10 masked while latched, then unmask
    chk("R10", "irq while masked", {31'b0, irq}, 32'h0);
    rdm(5'd15, '1, 32'h0, "R10");
    wr(5'd13, 32'h08);
    chk("R10", "irq after unmask", {31'b0, irq}, 32'h1);
    rdm(5'd15, '1, 32'h08, "R10");
    wr(5'd14, 32'h08);
    rdm(5'd14, 32'h08, 32'h00, "R8");
    chk("R10", "irq after clear", {31'b0, irq}, 32'h0);

    // R8 both edges: falling edge counts too
    wr(5'd11, 32'h08);
    pad_ext[3] = 1'b1; tick(3); rdm(5'd14, 32'h08, 32'h08, "R8");
    wr(5'd14, 32'h08);
    pad_ext[3] = 1'b0; tick(3); rdm(5'd14, 32'h08, 32'h08, "R8");
    wr(5'd14, 32'h08);
    wr(5'd11, 32'h00);

    // R9 level high
    wr(5'd10, 32'h08);
    pad_ext[3] = 1'b1; tick(3); rdm(5'd14, 32'h08, 32'h08, "R9");
    wr(5'd14, 32'h08); tick(1); rdm(5'd14, 32'h08, 32'h08, "R9");
    pad_ext[3] = 1'b0; tick(3); rdm(5'd14, 32'h08, 32'h00, "R9");

    // R5 no status from a disabled pin in low-level mode
    wr(5'd12, 32'h00);
    tick(1); chk("R9", "low level irq", {31'b0, irq}, 32'h1);
    wr(5'd6, 32'hF7);
    tick(1);
    rdm(5'd14, 32'h08, 32'h00, "R5");
    chk("R5", "no irq when disabled", {31'b0, irq}, 32'h0);
    wr(5'd6, 32'hFF);
    wr(5'd10, 32'h00); wr(5'd12, 32'h08); wr(5'd13, 32'h00);
    tick(3); wr(5'd14, 32'hFF);

    // R12 trigger pulses
    wr(5'd16, 32'h08);
    pad_ext[3] = 1'b1;
    cnt_a = 0; cnt_d = 0;
    for (int k = 0; k < 8; k++) begin
      tick(1);
      if (adc_trig) cnt_a++;
      if (dma_trig) cnt_d++;
    end
    chk("R12", "adc pulse count", cnt_a, 1);
    chk("R12", "dma pulse count (not enabled)", cnt_d, 0);
    wr(5'd16, 32'h00); wr(5'd17, 32'h08);
    pad_ext[3] = 1'b0; tick(4);
    pad_ext[3] = 1'b1;
    cnt_a = 0; cnt_d = 0;
    for (int k = 0; k < 8; k++) begin
      tick(1);
      if (adc_trig) cnt_a++;
      if (dma_trig) cnt_d++;
    end
    chk("R12", "dma pulse count", cnt_d, 1);
    chk("R12", "adc pulse count (disabled)", cnt_a, 0);

    // R13 stored-only registers
    wr(5'd7, 32'h5A); wr(5'd8, 32'hA5); wr(5'd9, 32'h3C);
    rdm(5'd7, '1, 32'h5A, "R13");
    rdm(5'd8, '1, 32'hA5, "R13");
    rdm(5'd9, '1, 32'h3C, "R13");
    chk("R13", "pads unaffected", {24'b0, pad_oe}, 32'h0);

    tick(2);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule